// File: doc/BRIEF.md
# Linked-Descriptor Transmit Engine

This block is the transmit half of a DMA channel. When started, it walks a singly linked chain of data descriptors held in memory. For each descriptor it streams the bytes of the described buffer to a client, one byte per handshake. When a buffer is exhausted, it writes the descriptor back. It then either follows the descriptor's next pointer, or it finishes the chain by marking the channel's context record as disabled.

Memory is reached through a word-wide read port and a word-wide write port. Both ports carry one outstanding access at a time. A buffer is described by a start address and an exclusive end address. The engine keeps its own byte position, so a caller can resume a transfer part-way through the first buffer.

Every stream handshake follows valid/ready rules. Once `out_valid` is raised, it stays high, with `out_data` and `out_last` unchanged, until `out_ready` is seen. A byte is consumed only in a cycle where both are high. The client may hold `out_ready` low for any number of cycles. The memory request ports follow the same rule for their address and write data. The engine waits for `rd_resp_valid`, which the memory must assert once per accepted read, in a later cycle.

Top module: `dtx_engine`

## Requirements
- R1: A descriptor is fetched as four word reads at offsets +0, +4, +8 and +12 from its address. The words hold, in that order, the next pointer, the buffer start, the flag word and the exclusive end pointer.
- R2: The bytes from the current position up to end−1 are streamed in ascending address order. The byte at address A is taken from bits 8·(A mod 4) upward of the word at A with its low two bits cleared. Under back-pressure, valid, data and last hold steady.
- R3: `out_last` is high on the final byte of a buffer when flag bit 3 is set, and low on every other byte.
- R4: A buffer whose end equals its position completes immediately and sends no bytes.
- R5: When a buffer completes and flag bit 4 is set, `intr_set` pulses for one cycle. The pulse comes before that descriptor's write-back.
- R6: After its buffer completes, the descriptor's four words are written back unchanged to the addresses they were read from. This happens before any further fetch or context write.
- R7: When flag bit 0 (end-of-list) is clear, the engine fetches the descriptor at the next pointer and starts from that descriptor's buffer start.
- R8: When flag bit 0 is set, the engine reads the context flag word at context address +4, sets bit 15 in it and writes it back. It then raises `eol` and drops `running` in the same cycle.
- R9: A `start` seen while idle clears `eol` and raises `running` one cycle later. A `start` seen while running has no effect on the transfer.
- R10: With `resume` high at start, the first buffer begins at `start_pos` instead of its buffer start. `cur_pos` ends equal to the last buffer's end pointer.
- R11: After MAX_BURST bytes have been sent from one descriptor with bytes still left, the engine re-fetches that descriptor and continues from the same position.
- R12: While idle, the engine issues no memory read or write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking a chain (sampled while idle) |
| resume | input | 1 | Use `start_pos` as the first buffer's position |
| start_desc | input | AW | Address of the first descriptor |
| start_pos | input | AW | Resume position for the first buffer |
| ctx_addr | input | AW | Address of the context record |
| running | output | 1 | Engine is walking a chain |
| eol | output | 1 | Chain finished at end-of-list |
| intr_set | output | 1 | One-cycle request to set raw interrupt bit 2 |
| cur_pos | output | AW | Current byte position |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read word address |
| rd_resp_valid | input | 1 | Read data returned |
| rd_resp_data | input | 32 | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | AW | Write word address |
| wr_data | output | 32 | Write data |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Client accepts byte |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of an end-of-packet buffer |

## Verification
Each result has a fixed point at which it is due:
- `running` and the cleared `eol` appear one edge after `start`. The bench samples them at the next falling edge.
- `eol` rises in the same edge that accepts the context write. The bench waits on `eol` and then checks memory and the logs, with nothing further in flight.
- The stream, the read and write addresses and the `intr_set` pulses are logged at every rising edge as handshakes complete. The `intr_set` pulse is logged with the number of writes already accepted, which proves it came before write-back.
- The sweep runs with the burst limit set to 8, so re-fetch counts can be computed as 1+⌊(len−1)/8⌋.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DESC_WORDS = 4;

  // word slots inside a data descriptor
  localparam int W_NEXT  = 0;
  localparam int W_BUF   = 1;
  localparam int W_FLAGS = 2;
  localparam int W_AFTER = 3;

  // flag bits
  localparam int FLG_EOL  = 0;
  localparam int FLG_EOP  = 3;
  localparam int FLG_INTR = 4;
  localparam int CTX_DIS  = 15;

  // byte offset of the flag word inside the context record
  localparam int CTX_FLAG_OFS = 4;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DRD_REQ,
    S_DRD_WAIT,
    S_EVAL,
    S_WRD_REQ,
    S_WRD_WAIT,
    S_EMIT,
    S_FIN,
    S_DWB,
    S_CRD_REQ,
    S_CRD_WAIT,
    S_CWB
  } dtx_state_e;
endpackage

// File: rtl/dtx_lane_pick.sv
module dtx_lane_pick #(
  parameter int LANES = 4,
  localparam int SW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [8*LANES-1:0] word_i,
  input  logic [SW-1:0]      sel_i,
  output logic [7:0]         byte_o
);
  logic [7:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[8*g +: 8];
  end

  assign byte_o = lane[sel_i];
endmodule

// File: rtl/dtx_burst_ctr.sv
module dtx_burst_ctr #(
  parameter int LIMIT = 2048,
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_cap
);
  logic [CW-1:0] cnt;

  // this increment completes a burst
  assign at_cap = inc && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (clr || at_cap)    cnt <= '0;
    else if (inc)              cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/dtx_engine.sv
module dtx_engine
  import dtx_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_BURST = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              resume,
  input  logic [AW-1:0]     start_desc,
  input  logic [AW-1:0]     start_pos,
  input  logic [AW-1:0]     ctx_addr,
  output logic              running,
  output logic              eol,
  output logic              intr_set,
  output logic [AW-1:0]     cur_pos,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_resp_valid,
  input  logic [WORD_W-1:0] rd_resp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last
);
  localparam int LW = $clog2(WORD_BYTES);
  localparam int IW = $clog2(DESC_WORDS);

  dtx_state_e st;
  logic [AW-1:0] desc_addr, ctx_q, pos;
  logic [DESC_WORDS-1:0][WORD_W-1:0] dw;
  logic [IW-1:0] wcnt;
  logic take_buf, eol_q;
  logic [WORD_W-1:0] word_q;

  logic [AW-1:0] pos_eff, end_a, pos_inc, word_off;
  logic final_byte, hs, at_cap;
  logic [7:0] lane_byte;

  assign end_a      = AW'(dw[W_AFTER]);
  assign pos_eff    = take_buf ? AW'(dw[W_BUF]) : pos;
  assign pos_inc    = pos + AW'(1);
  assign final_byte = (pos_inc == end_a);
  assign hs         = out_valid && out_ready;
  assign word_off   = AW'({wcnt, {LW{1'b0}}});

  dtx_lane_pick #(.LANES(WORD_BYTES)) u_pick (
    .word_i (word_q),
    .sel_i  (pos[LW-1:0]),
    .byte_o (lane_byte)
  );

  dtx_burst_ctr #(.LIMIT(MAX_BURST)) u_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (st == S_EVAL),
    .inc    (hs),
    .at_cap (at_cap)
  );

  always_comb begin
    rd_valid = 1'b0;
    rd_addr  = '0;
    wr_valid = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    unique case (st)
      S_DRD_REQ: begin
        rd_valid = 1'b1;
        rd_addr  = desc_addr + word_off;
      end
      S_WRD_REQ: begin
        rd_valid = 1'b1;
        rd_addr  = {pos[AW-1:LW], {LW{1'b0}}};
      end
      S_CRD_REQ: begin
        rd_valid = 1'b1;
        rd_addr  = ctx_q + AW'(CTX_FLAG_OFS);
      end
      S_DWB: begin
        wr_valid = 1'b1;
        wr_addr  = desc_addr + word_off;
        wr_data  = dw[wcnt];
      end
      S_CWB: begin
        wr_valid = 1'b1;
        wr_addr  = ctx_q + AW'(CTX_FLAG_OFS);
        wr_data  = word_q;
      end
      default: ;
    endcase
  end

  assign out_valid = (st == S_EMIT);
  assign out_data  = lane_byte;
  assign out_last  = out_valid && final_byte && dw[W_FLAGS][FLG_EOP];
  assign intr_set  = (st == S_FIN) && dw[W_FLAGS][FLG_INTR];
  assign running   = (st != S_IDLE);
  assign eol       = eol_q;
  assign cur_pos   = pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      desc_addr <= '0;
      ctx_q     <= '0;
      pos       <= '0;
      dw        <= '0;
      wcnt      <= '0;
      take_buf  <= 1'b0;
      eol_q     <= 1'b0;
      word_q    <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          eol_q     <= 1'b0;
          desc_addr <= start_desc;
          ctx_q     <= ctx_addr;
          pos       <= start_pos;
          take_buf  <= !resume;
          wcnt      <= '0;
          st        <= S_DRD_REQ;
        end
        S_DRD_REQ: if (rd_ready) st <= S_DRD_WAIT;
        S_DRD_WAIT: if (rd_resp_valid) begin
          dw[wcnt] <= rd_resp_data;
          if (wcnt == IW'(DESC_WORDS - 1)) begin
            wcnt <= '0;
            st   <= S_EVAL;
          end else begin
            wcnt <= wcnt + IW'(1);
            st   <= S_DRD_REQ;
          end
        end
        S_EVAL: begin
          pos      <= pos_eff;
          take_buf <= 1'b0;
          st       <= (pos_eff == end_a) ? S_FIN : S_WRD_REQ;
        end
        S_WRD_REQ: if (rd_ready) st <= S_WRD_WAIT;
        S_WRD_WAIT: if (rd_resp_valid) begin
          word_q <= rd_resp_data;
          st     <= S_EMIT;
        end
        S_EMIT: if (out_ready) begin
          pos <= pos_inc;
          if (final_byte)                          st <= S_FIN;
          else if (at_cap)                         st <= S_DRD_REQ;
          else if (pos[LW-1:0] == LW'(WORD_BYTES - 1)) st <= S_WRD_REQ;
        end
        S_FIN: begin
          wcnt <= '0;
          st   <= S_DWB;
        end
        S_DWB: if (wr_ready) begin
          if (wcnt == IW'(DESC_WORDS - 1)) begin
            wcnt <= '0;
            if (dw[W_FLAGS][FLG_EOL]) begin
              st <= S_CRD_REQ;
            end else begin
              desc_addr <= AW'(dw[W_NEXT]);
              take_buf  <= 1'b1;
              st        <= S_DRD_REQ;
            end
          end else begin
            wcnt <= wcnt + IW'(1);
          end
        end
        S_CRD_REQ: if (rd_ready) st <= S_CRD_WAIT;
        S_CRD_WAIT: if (rd_resp_valid) begin
          word_q <= rd_resp_data | (WORD_W'(1) << CTX_DIS);
          st     <= S_CWB;
        end
        S_CWB: if (wr_ready) begin
          eol_q <= 1'b1;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: a read request holds its address until accepted
  p_rd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R2: stream back-pressure keeps the byte steady
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R5: interrupt request is a single-cycle pulse
  p_intr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    intr_set |=> !intr_set);

  // R6: write requests hold address and data until accepted
  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R8: finished flag only while not running
  p_eol_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eol |-> !running);

  // R9: start from idle brings the engine up with the flag cleared
  p_start_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !running |=> running && !eol);

  // R12: no memory traffic while idle
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !rd_valid && !wr_valid);

  // R2: stream and memory ports are never active together
  p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rd_valid && !wr_valid);
endmodule

// File: tb/dtx_engine_bench.sv
module dtx_engine_bench;
  localparam int AW = 32;
  localparam int BURST = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 1'b0, resume = 1'b0;
  logic [AW-1:0] start_desc = '0, start_pos = '0, ctx_addr = '0;
  logic running, eol, intr_set;
  logic [AW-1:0] cur_pos, rd_addr, wr_addr;
  logic rd_valid, rd_ready, rd_resp_valid, wr_valid, wr_ready;
  logic [31:0] rd_resp_data, wr_data;
  logic out_valid, out_ready, out_last;
  logic [7:0] out_data;

  dtx_engine #(.AW(AW), .MAX_BURST(BURST)) u_dtx_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .resume(resume),
    .start_desc(start_desc), .start_pos(start_pos), .ctx_addr(ctx_addr),
    .running(running), .eol(eol), .intr_set(intr_set), .cur_pos(cur_pos),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  // memory model, logs and ready patterns
  logic [31:0] mem [0:255];
  logic [2:0] cyc = '0;
  logic tb_we = 1'b0, clr_log = 1'b0;
  logic [31:0] tb_wa = '0, tb_wd = '0;
  logic [7:0] cap_d [0:63];
  logic cap_l [0:63];
  int cap_n = 0, rd_n = 0, wr_n = 0, wr_desc_n = 0, intr_n = 0, intr_wr_at = -1;
  int df_n = 0;
  logic [31:0] df_a [0:15];
  logic [31:0] rd_a [0:15];

  assign out_ready = (cyc[1:0] != 2'd1);
  assign rd_ready  = (cyc != 3'd5);
  assign wr_ready  = (cyc != 3'd2);

  always @(posedge clk) begin
    cyc <= cyc + 3'd1;
    rd_resp_valid <= rd_valid && rd_ready;
    if (rd_valid && rd_ready) rd_resp_data <= mem[rd_addr[9:2]];
    if (tb_we) mem[tb_wa[9:2]] <= tb_wd;
    else if (wr_valid && wr_ready) mem[wr_addr[9:2]] <= wr_data;
    if (clr_log) begin
      cap_n <= 0; rd_n <= 0; wr_n <= 0; wr_desc_n <= 0; intr_n <= 0;
      intr_wr_at <= -1; df_n <= 0;
    end else begin
      if (out_valid && out_ready && cap_n < 64) begin
        cap_d[cap_n] <= out_data; cap_l[cap_n] <= out_last; cap_n <= cap_n + 1;
      end
      if (rd_valid && rd_ready) begin
        if (rd_n < 16) rd_a[rd_n] <= rd_addr;
        rd_n <= rd_n + 1;
        if (rd_addr < 32'h100 && rd_addr[3:0] == 4'h0) begin
          if (df_n < 16) df_a[df_n] <= rd_addr;
          df_n <= df_n + 1;
        end
      end
      if (wr_valid && wr_ready) begin
        wr_n <= wr_n + 1;
        if (wr_addr < 32'h100) wr_desc_n <= wr_desc_n + 1;
      end
      if (intr_set) begin
        intr_n <= intr_n + 1;
        if (intr_wr_at < 0) intr_wr_at <= wr_n;
      end
    end
  end

  int n_run = 0, n_fail = 0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    logic [31:0] v;
    v = a * 32'd7 + 32'd3;
    return v[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_wa = a; tb_wd = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] b, nx, bf, fl, af);
    poke(b, nx); poke(b + 32'd4, bf); poke(b + 32'd8, fl); poke(b + 32'd12, af);
  endtask

  task automatic run_job(input logic [31:0] d, input logic [31:0] ctx,
                         input logic [31:0] p, input bit res, input bit disturb);
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
    start_desc = d; ctx_addr = ctx; start_pos = p; resume = res; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(running && !eol, "R9", "running/eol after start", {30'd0, running, eol}, 32'h2);
    if (disturb) begin
      repeat (6) @(negedge clk);
      start_desc = 32'h30; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int t = 0; t < 4000 && !eol; t++) @(negedge clk);
    chk(eol && !running, "R8", "end state", {30'd0, running, eol}, 32'h1);
  endtask

  // sweep over offset, length and flags for one end-of-list descriptor
  task automatic sweep_case(input int off, input int len);
    logic [31:0] bf, fl, exp_fetch;
    bit eop, intr, bytes_ok, last_ok;
    eop  = off[0] ^ len[0];
    intr = len[1];
    bf   = 32'h200 + 32'(off);
    fl   = 32'h00A5_0001 | (32'(eop) << 3) | (32'(intr) << 4);
    put_desc(32'h10, 32'h0, bf, fl, bf + 32'(len));
    poke(32'h104, 32'h3);
    run_job(32'h10, 32'h100, 32'h0, 1'b0, 1'b0);
    bytes_ok = (cap_n == len);
    last_ok  = 1'b1;
    for (int i = 0; i < len && i < 64; i++) begin
      if (cap_d[i] !== pat(bf + 32'(i))) bytes_ok = 1'b0;
      if (cap_l[i] !== (eop && i == len - 1)) last_ok = 1'b0;
    end
    chk(bytes_ok, (len == 0) ? "R4" : "R2", "byte stream", 32'(cap_n), 32'(len));
    chk(last_ok, "R3", "last marker", 32'(off), 32'(len));
    chk(intr_n == int'(intr), "R5", "interrupt pulses", 32'(intr_n), 32'(intr));
    if (intr) chk(intr_wr_at == 0, "R5", "pulse before write-back", 32'(intr_wr_at), 32'h0);
    chk(wr_desc_n == 4 && wr_n == 5, "R6", "write-back count", 32'(wr_desc_n), 32'h4);
    chk(mem[8'h06] == fl && mem[8'h07] == bf + 32'(len), "R6", "descriptor unchanged",
        mem[8'h06], fl);
    chk(mem[8'h41] == 32'h8003, "R8", "context disable bit", mem[8'h41], 32'h8003);
    exp_fetch = (len == 0) ? 32'd1 : 32'd1 + 32'((len - 1) / BURST);
    chk(32'(df_n) == exp_fetch, "R11", "descriptor fetch count", 32'(df_n), exp_fetch);
  endtask

  initial begin
    for (int w = 128; w < 256; w++) begin
      @(negedge clk); tb_we = 1'b1; tb_wa = 32'(w * 4);
      tb_wd = {pat(32'(w*4+3)), pat(32'(w*4+2)), pat(32'(w*4+1)), pat(32'(w*4))};
    end
    @(negedge clk); tb_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!running && !eol && !out_valid && !rd_valid && !wr_valid && !intr_set,
        "R12", "reset state", {27'd0, running, eol, out_valid, rd_valid, wr_valid}, 32'h0);

    for (int off = 0; off < 4; off++)
      for (int len = 0; len < 12; len++) sweep_case(off, len);

    // R7: three-link chain with an empty middle buffer
    put_desc(32'h20, 32'h40, 32'h281, 32'h10, 32'h286);
    put_desc(32'h40, 32'h60, 32'h2C2, 32'h10, 32'h2C2);
    put_desc(32'h60, 32'h0, 32'h303, 32'h9, 32'h30A);
    poke(32'h104, 32'h0);
    run_job(32'h20, 32'h100, 32'h0, 1'b0, 1'b0);
    begin
      bit ok;
      logic [31:0] a;
      ok = (cap_n == 12);
      for (int i = 0; i < 12; i++) begin
        a = (i < 5) ? 32'h281 + 32'(i) : 32'h303 + 32'(i - 5);
        if (cap_d[i] !== pat(a) || cap_l[i] !== (i == 11)) ok = 1'b0;
      end
      chk(ok, "R7", "chained stream", 32'(cap_n), 32'd12);
      chk(df_n == 3 && df_a[0] == 32'h20 && df_a[1] == 32'h40 && df_a[2] == 32'h60,
          "R7", "fetch order", df_a[1], 32'h40);
      chk(intr_n == 2, "R5", "chain pulses", 32'(intr_n), 32'd2);
      chk(mem[8'h41] == 32'h8000, "R8", "chain context word", mem[8'h41], 32'h8000);
    end

    // R10 and R1: resume part-way through a buffer
    put_desc(32'h10, 32'h0, 32'h200, 32'h1, 32'h20A);
    run_job(32'h10, 32'h100, 32'h206, 1'b1, 1'b0);
    begin
      bit ok;
      ok = (cap_n == 4);
      for (int i = 0; i < 4; i++) if (cap_d[i] !== pat(32'h206 + 32'(i))) ok = 1'b0;
      chk(ok, "R10", "resumed stream", 32'(cap_n), 32'd4);
      chk(cur_pos == 32'h20A, "R10", "final position", cur_pos, 32'h20A);
      chk(rd_a[0] == 32'h10 && rd_a[1] == 32'h14 && rd_a[2] == 32'h18 && rd_a[3] == 32'h1C,
          "R1", "descriptor word order", rd_a[3], 32'h1C);
      chk(rd_a[4] == 32'h204, "R2", "first data word", rd_a[4], 32'h204);
    end

    // R9: start during a transfer is ignored
    put_desc(32'h30, 32'h0, 32'h380, 32'h1, 32'h390);
    put_desc(32'h10, 32'h0, 32'h201, 32'h1, 32'h20C);
    run_job(32'h10, 32'h100, 32'h0, 1'b0, 1'b1);
    begin
      bit ok;
      ok = (cap_n == 11);
      for (int i = 0; i < 11; i++) if (cap_d[i] !== pat(32'h201 + 32'(i))) ok = 1'b0;
      chk(ok, "R9", "stream after ignored start", 32'(cap_n), 32'd11);
      chk(df_n == 2 && df_a[1] == 32'h10, "R9", "no fetch of other chain", df_a[1], 32'h10);
    end

    // R12: quiet while idle
    begin
      int r0, w0;
      r0 = rd_n; w0 = wr_n;
      repeat (30) @(negedge clk);
      chk(rd_n == r0 && wr_n == w0 && !running, "R12", "idle traffic",
          32'(rd_n - r0 + wr_n - w0), 32'h0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule